// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steps a processor core between its running state and two power-saving states. Light idle stops the core clock but keeps the PLL running, so state survives and the core can resume. Deep sleep also turns the PLL off; the core's supply may then be removed, and only a reset brings the core back. A mode change starts with a request that carries a 2-bit target code. The block then waits for the core to report that all outstanding work has finished before it gates anything.

While in light idle, a low level on either interrupt pin (FIQ or IRQ, both active low) starts the return to running. The pins first pass through a two-flop synchronizer. The interrupt mask bits play no part in this decision and are handed on to the core unchanged, so a masked interrupt still wakes the core. The return is not immediate: the status keeps reporting idle for a fixed count of cycles. A one-cycle wake pulse marks the first running cycle.

Top module: `pwr_mode_seq`

## Requirements
- R1: While the reset input is low, and after it is released, the block is running: status 2'b00, core clock enable 1, PLL enable 1, wake pulse 0. Reset overrides every other input, including deep sleep.
- R2: The status output never shows the reserved code 2'b10.
- R3: An accepted request does not change the status, and keeps the core clock enabled, until the drained input is seen high. The new status appears one cycle after the first cycle in which drained is high.
- R4: In light idle the status is 2'b01, the core clock enable is 0 and the PLL enable stays 1.
- R5: In light idle, a low level on FIQ or on IRQ causes a wake. The wake is taken on the third rising edge after the pin goes low (two synchronizer flops plus one state update), whatever the mask bits are.
- R6: The FIQ and IRQ mask outputs always equal the mask inputs.
- R7: After the wake is taken, the status stays 2'b01 for EXIT_CYCLES cycles (default 10). It shows 2'b00, with the core clock enabled, EXIT_CYCLES+3 cycles after the pin went low.
- R8: In deep sleep the status is 2'b11 and both the core clock enable and the PLL enable are 0. Interrupt pins and requests have no effect there; only reset leaves it.
- R9: A request is accepted only while running and only with target code 2'b01 (light idle) or 2'b11 (deep sleep). Codes 2'b00 and 2'b10, and requests made in any other state, are ignored.
- R10: The wake output is high for exactly one cycle: the first running cycle after a return from light idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset; asserts asynchronously and is released synchronously inside the block |
| enter_req_i | input | 1 | Request to enter the mode given by target_mode_i |
| target_mode_i | input | 2 | Requested mode: 01 light idle, 11 deep sleep, other codes ignored |
| drained_i | input | 1 | Core reports that no work is outstanding |
| fiq_ni | input | 1 | Fast interrupt pin, active low |
| irq_ni | input | 1 | Normal interrupt pin, active low |
| fiq_mask_i | input | 1 | Fast interrupt mask (1 = masked) |
| irq_mask_i | input | 1 | Normal interrupt mask (1 = masked) |
| status_o | output | 2 | Power status: 00 running, 01 light idle, 11 deep sleep |
| core_clk_en_o | output | 1 | Core clock gate enable |
| pll_en_o | output | 1 | PLL enable |
| wake_o | output | 1 | One-cycle pulse on the return to running from light idle |
| fiq_mask_o | output | 1 | Fast interrupt mask handed on to the core |
| irq_mask_o | output | 1 | Normal interrupt mask handed on to the core |

## Verification
The hardest case to reach from the ports is deep sleep with both interrupt pins held low and a fresh request pending. That is the one place where the sequencer must ignore every input except reset. The stimulus gets there by a full request-and-drain sequence into sleep. It then holds both pins low and a light-idle request for longer than a full wake path would take, and finally pulls reset while still asleep. The idle exit is run twice, once with a masked FIQ and once with an unmasked IRQ, and the exact cycle of the status change and the wake pulse is checked each time.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    PM_RUN   = 3'd0,
    PM_DRAIN = 3'd1,
    PM_IDLE  = 3'd2,
    PM_EXIT  = 3'd3,
    PM_SLEEP = 3'd4
  } pm_state_e;

  localparam logic [1:0] PSTAT_RUN   = 2'b00;
  localparam logic [1:0] PSTAT_IDLE  = 2'b01;
  localparam logic [1:0] PSTAT_RSVD  = 2'b10;
  localparam logic [1:0] PSTAT_SLEEP = 2'b11;

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  // assert at once, release after STAGES edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o
);

  // one shift chain per pin; resets to the inactive (high) level
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q <= '1;
      end else begin
        sh_q <= {sh_q[STAGES-2:0], pin_i[b]};
      end
    end

    assign pin_o[b] = sh_q[STAGES-1];
  end

endmodule

// File: rtl/pwr_exit_timer.sv
module pwr_exit_timer #(
  parameter int CYCLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);

  localparam int              CW   = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0]   LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start_i) begin
      run_d = 1'b1;
      cnt_d = LOAD;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign done_o = run_q && (cnt_q == '0);

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enter_req_i,
  input  logic [1:0] target_i,
  input  logic       drained_i,
  input  logic       wake_evt_i,
  input  logic       exit_done_i,
  output logic       exit_start_o,
  output logic [1:0] status_o,
  output logic       core_clk_en_o,
  output logic       pll_en_o,
  output logic       wake_o
);

  pm_state_e  state_q, state_d;
  logic [1:0] tgt_q;
  logic       tgt_ld;
  logic       wake_q, wake_d;
  logic       req_ok;

  // only the two low-power codes are accepted
  assign req_ok = enter_req_i &&
                  ((target_i == PSTAT_IDLE) || (target_i == PSTAT_SLEEP));

  always_comb begin
    state_d      = state_q;
    tgt_ld       = 1'b0;
    wake_d       = 1'b0;
    exit_start_o = 1'b0;
    case (state_q)
      PM_RUN: begin
        if (req_ok) begin
          state_d = PM_DRAIN;
          tgt_ld  = 1'b1;
        end
      end
      PM_DRAIN: begin
        if (drained_i) begin
          state_d = (tgt_q == PSTAT_SLEEP) ? PM_SLEEP : PM_IDLE;
        end
      end
      PM_IDLE: begin
        if (wake_evt_i) begin
          state_d      = PM_EXIT;
          exit_start_o = 1'b1;
        end
      end
      PM_EXIT: begin
        if (exit_done_i) begin
          state_d = PM_RUN;
          wake_d  = 1'b1;
        end
      end
      PM_SLEEP: state_d = PM_SLEEP;
      default:  state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PM_RUN;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= PSTAT_RUN;
    end else if (tgt_ld) begin
      tgt_q <= target_i;
    end
  end

  always_comb begin
    status_o      = PSTAT_RUN;
    core_clk_en_o = 1'b1;
    pll_en_o      = 1'b1;
    case (state_q)
      PM_IDLE, PM_EXIT: begin
        status_o      = PSTAT_IDLE;
        core_clk_en_o = 1'b0;
      end
      PM_SLEEP: begin
        status_o      = PSTAT_SLEEP;
        core_clk_en_o = 1'b0;
        pll_en_o      = 1'b0;
      end
      default: ;
    endcase
  end

  assign wake_o = wake_q;

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int EXIT_CYCLES = 10,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enter_req_i,
  input  logic [1:0] target_mode_i,
  input  logic       drained_i,
  input  logic       fiq_ni,
  input  logic       irq_ni,
  input  logic       fiq_mask_i,
  input  logic       irq_mask_i,
  output logic [1:0] status_o,
  output logic       core_clk_en_o,
  output logic       pll_en_o,
  output logic       wake_o,
  output logic       fiq_mask_o,
  output logic       irq_mask_o
);

  localparam int NPINS = 2;

  logic             rst_n;
  logic [NPINS-1:0] pins_sync;
  logic             wake_evt;
  logic             exit_start;
  logic             exit_done;

  pwr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  pwr_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_pins (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .pin_i  ({irq_ni, fiq_ni}),
    .pin_o  (pins_sync)
  );

  // any pin low wakes; masks are deliberately not consulted
  assign wake_evt = ~&pins_sync;

  pwr_exit_timer #(.CYCLES(EXIT_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .start_i (exit_start),
    .done_o  (exit_done)
  );

  pwr_mode_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .enter_req_i   (enter_req_i),
    .target_i      (target_mode_i),
    .drained_i     (drained_i),
    .wake_evt_i    (wake_evt),
    .exit_done_i   (exit_done),
    .exit_start_o  (exit_start),
    .status_o      (status_o),
    .core_clk_en_o (core_clk_en_o),
    .pll_en_o      (pll_en_o),
    .wake_o        (wake_o)
  );

  assign fiq_mask_o = fiq_mask_i;
  assign irq_mask_o = irq_mask_i;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       drained_i,
  input logic [1:0] status_o,
  input logic       core_clk_en_o,
  input logic       pll_en_o,
  input logic       wake_o
);

  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (status_o == 2'b00) && core_clk_en_o && pll_en_o && !wake_o);

  assert_no_reserved_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'b10);

  assert_wait_drain_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'b00 && !drained_i) |=> (status_o == 2'b00));

  assert_idle_pll_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'b01) |-> (pll_en_o && !core_clk_en_o));

  assert_sleep_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'b11) |-> (!pll_en_o && !core_clk_en_o));

  assert_sleep_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'b11) |=> (status_o == 2'b11));

  assert_wake_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  assert_wake_from_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (status_o == 2'b00) && ($past(status_o) == 2'b01));

endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .drained_i     (drained_i),
  .status_o      (status_o),
  .core_clk_en_o (core_clk_en_o),
  .pll_en_o      (pll_en_o),
  .wake_o        (wake_o)
);

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;

  localparam int E = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       enter_req = 1'b0;
  logic [1:0] target = 2'b00;
  logic       drained = 1'b0;
  logic       fiq_n = 1'b1;
  logic       irq_n = 1'b1;
  logic       fiq_mask = 1'b0;
  logic       irq_mask = 1'b0;
  logic [1:0] status;
  logic       cen, pll, wake, fmo, imo;

  int  cyc = 0;
  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  bit  rsvd_seen = 1'b0;

  typedef struct {
    int         at;
    logic [1:0] st;
    logic       cen;
    logic       pll;
    logic       wk;
    logic       fm;
    logic       im;
    string      tag;
  } exp_t;

  exp_t sb[$];
  exp_t it;

  always #4 clk = ~clk;   // 125 MHz

  pwr_mode_seq #(.EXIT_CYCLES(E)) u0 (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .enter_req_i   (enter_req),
    .target_mode_i (target),
    .drained_i     (drained),
    .fiq_ni        (fiq_n),
    .irq_ni        (irq_n),
    .fiq_mask_i    (fiq_mask),
    .irq_mask_i    (irq_mask),
    .status_o      (status),
    .core_clk_en_o (cen),
    .pll_en_o      (pll),
    .wake_o        (wake),
    .fiq_mask_o    (fmo),
    .irq_mask_o    (imo)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop and compare the items due at this sample point
  always @(negedge clk) begin
    if (rst_ni && status == 2'b10) rsvd_seen = 1'b1;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      it = sb.pop_front();
      checks++;
      if (status !== it.st || cen !== it.cen || pll !== it.pll ||
          wake !== it.wk || fmo !== it.fm || imo !== it.im) begin
        fails++;
        $display("FAIL %s: got st=%b cen=%b pll=%b wake=%b fm=%b im=%b, exp st=%b cen=%b pll=%b wake=%b fm=%b im=%b",
                 it.tag, status, cen, pll, wake, fmo, imo,
                 it.st, it.cen, it.pll, it.wk, it.fm, it.im);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 5000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, got cycle %0d, exp below 5000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // driver: push what the outputs must be dly edges from now
  task automatic expect_at(input int dly, input logic [1:0] st, input logic c,
                           input logic p, input logic w, input string tag);
    exp_t e;
    e.at = cyc + dly; e.st = st; e.cen = c; e.pll = p; e.wk = w;
    e.fm = fiq_mask; e.im = irq_mask; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    #3 rst_ni = 1'b0;
    tick(2);
    expect_at(1, 2'b00, 1, 1, 0, "R1 reset state");
    tick(2);
    rst_ni = 1'b1;
    tick(4);

    // light idle entry, drained held off
    enter_req = 1'b1; target = 2'b01; drained = 1'b0;
    expect_at(1, 2'b00, 1, 1, 0, "R3 draining");
    tick(1);
    enter_req = 1'b0;
    expect_at(3, 2'b00, 1, 1, 0, "R3 hold until drained");
    tick(3);
    drained = 1'b1;
    expect_at(1, 2'b01, 0, 1, 0, "R4 idle entered");
    tick(1);
    drained = 1'b0;

    // request while idle
    enter_req = 1'b1; target = 2'b11; drained = 1'b1;
    expect_at(2, 2'b01, 0, 1, 0, "R9 request in idle ignored");
    tick(1);
    enter_req = 1'b0; drained = 1'b0;
    tick(2);

    // masked FIQ wake
    fiq_mask = 1'b1; irq_mask = 1'b1;
    fiq_n = 1'b0;
    expect_at(2, 2'b01, 0, 1, 0, "R5 still idle while synchronizing, R6 masks");
    expect_at(3, 2'b01, 0, 1, 0, "R7 exit started");
    expect_at(E + 2, 2'b01, 0, 1, 0, "R7 last exit cycle");
    expect_at(E + 3, 2'b00, 1, 1, 1, "R5 masked fiq wakes, R10 pulse");
    expect_at(E + 4, 2'b00, 1, 1, 0, "R10 pulse lasts one cycle");
    tick(E + 5);
    fiq_n = 1'b1;
    tick(1);
    fiq_mask = 1'b0; irq_mask = 1'b0;

    // reserved and normal codes ignored
    enter_req = 1'b1; target = 2'b10; drained = 1'b1;
    expect_at(1, 2'b00, 1, 1, 0, "R9 code 10 ignored");
    tick(1);
    target = 2'b00;
    expect_at(3, 2'b00, 1, 1, 0, "R9 code 00 ignored");
    tick(1);
    enter_req = 1'b0;
    tick(3);

    // idle again, unmasked IRQ wake
    enter_req = 1'b1; target = 2'b01;
    expect_at(2, 2'b01, 0, 1, 0, "R4 idle with drained already high");
    tick(1);
    enter_req = 1'b0;
    tick(2);
    drained = 1'b0;
    irq_n = 1'b0;
    expect_at(E + 2, 2'b01, 0, 1, 0, "R7 irq exit still idle");
    expect_at(E + 3, 2'b00, 1, 1, 1, "R5 irq wake");
    tick(E + 5);
    irq_n = 1'b1;
    tick(2);

    // deep sleep, then everything but reset
    enter_req = 1'b1; target = 2'b11; drained = 1'b1;
    expect_at(2, 2'b11, 0, 0, 0, "R8 sleep entered");
    tick(1);
    enter_req = 1'b0;
    tick(2);
    fiq_n = 1'b0; irq_n = 1'b0;
    enter_req = 1'b1; target = 2'b01;
    expect_at(E + 6, 2'b11, 0, 0, 0, "R8 pins and requests ignored in sleep");
    tick(E + 7);
    fiq_n = 1'b1; irq_n = 1'b1; enter_req = 1'b0; drained = 1'b0;
    tick(1);

    rst_ni = 1'b0;
    expect_at(1, 2'b00, 1, 1, 0, "R1 reset leaves sleep");
    tick(2);
    rst_ni = 1'b1;
    tick(4);
    expect_at(1, 2'b00, 1, 1, 0, "R1 running after release");
    tick(3);

    checks++;
    if (rsvd_seen) begin
      fails++;
      $display("FAIL R2: got status 10 at some point, exp never");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule